// File: doc/BRIEF.md
# Unsigned 32-by-16 Iterative Divider with Overflow Flag

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor. The dividend sits in two 16-bit word registers, a high word and a low word, which are written before the operation starts. The results go back into the same pair: the quotient into the low word and the remainder into the high word. The divisor is presented on its own input in the cycle that starts the division.

Overflow is settled before any iteration runs. When the divisor is not strictly greater than the high word, the quotient cannot fit in 16 bits. The block then raises the overflow flag and writes FFFFh into the low word in a single cycle. A divisor of zero is one such case. The same rule covers operands where the top bit of both the high word and the divisor is set, so those cases are flagged correctly. Otherwise a restoring shift-subtract loop produces one quotient bit per clock, and the result is ready after 16 iterations. A one-cycle done pulse marks the end of every operation.

Top module: `udiv32_16`

## Requirements
- R1: While rst_ni is low and after its release, hi_o, lo_o, busy_o, done_o and ovf_o are all 0.
- R2: When busy_o is 0 and no start is accepted, hi_we_i loads wr_data_i into the high word and lo_we_i loads wr_data_i into the low word. The new value is visible on hi_o or lo_o in the next cycle.
- R3: A start is accepted when start_i is 1 while busy_o is 0. In the next cycle ovf_o is 1 if divisor_i is less than or equal to the high word, and 0 otherwise. ovf_o holds that value until the next accepted start.
- R4: On an accepted start with overflow, lo_o becomes FFFFh in the next cycle and hi_o is unchanged. In that same cycle done_o is 1 for one cycle, and busy_o stays 0.
- R5: On an accepted start without overflow, busy_o is 1 for exactly 16 cycles, beginning in the next cycle. done_o is then 1 for exactly one cycle, the first cycle in which busy_o is back at 0.
- R6: When a division without overflow completes, lo_o holds the quotient floor({hi,lo}/divisor) and hi_o holds the remainder, which is less than the divisor.
- R7: While busy_o is 1, start_i, divisor_i, hi_we_i and lo_we_i have no effect on the result.
- R8: Operands with bit 15 set in both the high word and the divisor are flagged by the same rule. For example, F0F00F0Fh divided by F0F0h sets ovf_o and gives lo_o = FFFFh, and 80000000h divided by 8001h completes without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_we_i | input | 1 | Write enable for the high word |
| lo_we_i | input | 1 | Write enable for the low word |
| wr_data_i | input | 16 | Data written into the high or low word |
| start_i | input | 1 | Start request |
| divisor_i | input | 16 | Divisor, sampled when a start is accepted |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Overflow flag of the last accepted operation |
| hi_o | output | 16 | High word: dividend high, then remainder |
| lo_o | output | 16 | Low word: dividend low, then quotient |

## Verification
The assertions check the following on every cycle:
- the overflow decision against the sampled divisor and high word;
- the single-cycle overflow completion;
- the pairing of the falling edge of busy with a single done pulse;
- the stability of the captured divisor while busy;
- that the remainder is below the divisor whenever a division completes without overflow.

The exact quotient and remainder values need the bench's reference model; no per-cycle property can show them. The same holds for the boundary cases: divisor equal to the high word, divisor zero, operands with both top bits set, and starts and writes that arrive while busy.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } udiv_state_e;
endpackage

// File: rtl/udiv_ovf_detect.sv
module udiv_ovf_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] dvs_i,
  output logic         ovf_o
);
  // Quotient fits in W bits only if divisor > high word; covers zero divisor.
  assign ovf_o = (dvs_i <= hi_i);
endmodule

// File: rtl/udiv_step.sv
module udiv_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvd_o
);
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         ge;

  assign trial = {rem_i, dvd_i[W-1]};
  assign ge    = (trial >= {1'b0, dvs_i});
  // Only used when ge: true difference is below dvs, fits in W bits.
  assign diff  = trial[W-1:0] - dvs_i;
  assign rem_o = ge ? diff : trial[W-1:0];
  assign dvd_o = {dvd_i[W-2:0], ge};
endmodule

// File: rtl/udiv_seq.sv
module udiv_seq
  import udiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic bypass_i,
  output logic step_en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(W);

  udiv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (launch_i && bypass_i) begin
            done_q <= 1'b1;
          end else if (launch_i) begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_W'(W - 1);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  assign step_en_o = (state_q == ST_RUN);
  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;

  // R5
  busy_end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/udiv32_16.sv
module udiv32_16 #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hi_we_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         start_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         ovf_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_q, lo_q, dvs_q;
  logic         ovf_q;
  logic         launch, ovf_det, step_en, busy;
  logic [W-1:0] step_rem, step_dvd;

  assign launch = start_i && !busy;

  udiv_ovf_detect #(.W(W)) u_ovf (
    .hi_i  (hi_q),
    .dvs_i (divisor_i),
    .ovf_o (ovf_det)
  );

  udiv_step #(.W(W)) u_step (
    .rem_i (hi_q),
    .dvd_i (lo_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .dvd_o (step_dvd)
  );

  udiv_seq #(.W(W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .bypass_i  (ovf_det),
    .step_en_o (step_en),
    .busy_o    (busy),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      dvs_q <= '0;
      ovf_q <= 1'b0;
    end else if (launch) begin
      dvs_q <= divisor_i;
      ovf_q <= ovf_det;
      if (ovf_det) lo_q <= '1;
    end else if (step_en) begin
      hi_q <= step_rem;
      lo_q <= step_dvd;
    end else begin
      if (hi_we_i) hi_q <= wr_data_i;
      if (lo_we_i) lo_q <= wr_data_i;
    end
  end

  assign busy_o = busy;
  assign ovf_o  = ovf_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R3
  ovf_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (ovf_o == ($past(divisor_i) <= $past(hi_q))));

  // R4
  ovf_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && ovf_det) |=> (lo_q == '1 && done_o && !busy_o && hi_q == $past(hi_q)));

  // R6
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ovf_o) |-> (hi_q < dvs_q));

  // R7
  dvs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dvs_q));
endmodule

// File: tb/udiv32_16_bench.sv
`timescale 1ns/1ps
module udiv32_16_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hi_we = 1'b0, lo_we = 1'b0, start = 1'b0;
  logic [15:0] wr_data = '0, divisor = '0;
  logic        busy, done, ovf;
  logic [15:0] hi, lo;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  udiv32_16 u_udiv32_16 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .hi_we_i   (hi_we),
    .lo_we_i   (lo_we),
    .wr_data_i (wr_data),
    .start_i   (start),
    .divisor_i (divisor),
    .busy_o    (busy),
    .done_o    (done),
    .ovf_o     (ovf),
    .hi_o      (hi),
    .lo_o      (lo)
  );

  // Behavioural reference model
  logic [15:0] m_hi = '0, m_lo = '0;
  logic        m_busy = 1'b0, m_done = 1'b0, m_ovf = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_q, m_r;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hi = '0; m_lo = '0; m_busy = 1'b0; m_done = 1'b0; m_ovf = 1'b0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1;
          m_hi = m_r[15:0]; m_lo = m_q[15:0];
        end
      end else if (start) begin
        if (divisor <= m_hi) begin
          m_ovf = 1'b1; m_lo = 16'hFFFF; m_done = 1'b1;
        end else begin
          m_ovf = 1'b0; m_busy = 1'b1; m_cnt = 16;
          m_q = {m_hi, m_lo} / {16'h0, divisor};
          m_r = {m_hi, m_lo} % {16'h0, divisor};
        end
      end else begin
        if (hi_we) m_hi = wr_data;
        if (lo_we) m_lo = wr_data;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(rst_ni ? "R5" : "R1", "busy", busy, m_busy);
      chk(rst_ni ? "R5" : "R1", "done", done, m_done);
      chk(rst_ni ? "R3" : "R1", "ovf", ovf, m_ovf);
      if (!m_busy) begin
        chk(rst_ni ? tag : "R1", "hi", hi, m_hi);
        chk(rst_ni ? tag : "R1", "lo", lo, m_lo);
      end
    end
  end

  task automatic load(logic [15:0] h, logic [15:0] l);
    @(negedge clk); hi_we = 1'b1; wr_data = h;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wr_data = l;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic run(logic [15:0] d);
    start = 1'b1; divisor = d;
    @(negedge clk); start = 1'b0;
    repeat (19) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    tag = "R2"; load(16'h1234, 16'h5678);
    tag = "R4"; run(16'h1234);            // divisor equal to high word: overflow
    tag = "R6"; load(16'h1234, 16'h5678); run(16'h1235);
    tag = "R8"; load(16'hF0F0, 16'h0F0F); run(16'hF0F0);
    tag = "R8"; load(16'h8000, 16'h0000); run(16'h8001);
    tag = "R6"; load(16'hFFFE, 16'hFFFF); run(16'hFFFF);
    tag = "R4"; load(16'h0000, 16'h0005); run(16'h0000); // divide by zero
    tag = "R6"; load(16'h0000, 16'h0005); run(16'h0007);
    tag = "R6"; load(16'h0000, 16'hFFFF); run(16'h0001);
    // R7: start and writes while busy are ignored
    tag = "R7"; load(16'h0ABC, 16'hDEF0);
    start = 1'b1; divisor = 16'h1235;
    @(negedge clk); divisor = 16'h0001; hi_we = 1'b1; lo_we = 1'b1; wr_data = 16'hFFFF;
    repeat (5) @(negedge clk);
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    repeat (16) @(negedge clk);
    // R3: flag persists, then clears on a later non-overflow start
    tag = "R3"; load(16'h0001, 16'h0000); run(16'h0001);
    load(16'h0001, 16'h0000); run(16'h0002);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog R5: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule